// File: doc/BRIEF.md
# Cascaded Vectored Interrupt Controller

This block collects 40 primary interrupt sources and a second group of 32 sources and drives one interrupt request line to the processor. Software reaches the block through a single-cycle bus. Each bus access carries a byte address, 32-bit write data and a write strobe. Reads return data from the combinational read path in the same cycle.

Each primary source has its own pending latch. Two configuration bits shape that latch: one picks the active level, the other picks edge or level capture. A source requests service when its latch is set and its enable bit is set. Enables change only through write-one-to-set and write-one-to-clear addresses, so software never needs a read-modify-write. A priority register returns the lowest-numbered source that is both pending and enabled.

The second group has its own status, clear and enable registers. When any of its sources is both pending and enabled, that request becomes the input of primary source 0. The block also holds a bank of small channel mapping registers that software can read and write.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset, the following are zero: all primary pending flags, primary enables, polarity bits, type bits, secondary status and secondary enables. `cpu_irq` is low, and the priority register reads 63.
- R2: Enable registers. A write to 0x20 (sources 0–31) or 0x24 (sources 32–39 in bits 7:0) sets each enable bit written as 1. A write to 0x30 or 0x34 clears each enable bit written as 1. Bits written as 0 keep their value. Reading either the set address or the clear address of a word returns the current enable mask.
- R3: A primary pending flag latches regardless of its enable. It stays set until a 1 is written to its bit at 0x10 (sources 0–31) or 0x14 (sources 32–39 in bits 7:0). Both addresses read back the pending flags.
- R4: Address 0x40 returns, in bits 5:0, the lowest-numbered source that is both pending and enabled. When no source qualifies it returns 63. All other bits read as 0.
- R5: `cpu_irq` is high exactly when at least one primary source is both pending and enabled.
- R6: Polarity bits live at 0x50 and 0x54. A bit value of 1 makes that source active when its input is low. A value of 0 makes it active when its input is high.
- R7: Type bits live at 0x60 and 0x64. A value of 1 selects edge capture: the flag sets only in a cycle where the source turns active after being inactive in the previous cycle. A value of 0 selects level capture: the flag sets in every cycle the source is active, so a clear has no effect while the source stays active.
- R8: Secondary status reads at 0x80 and at 0x88. A status bit sets in every cycle its input is high, and holds until a 1 is written to that bit at 0x88. Writing a 1 at 0x90 sets a secondary enable bit, and writing a 1 at 0x98 clears it. Both 0x90 and 0x98 read back the mask.
- R9: Primary source 0 takes as its input the OR of all secondary status bits that are enabled, and that input passes through source 0's polarity and type settings. The `prim_in` port drives primary sources 1–39.
- R10: Channel mapping register n sits at 0x200 + 4n for n = 0..39. It holds a 6-bit value in bits 5:0 and resets to n. Aligned addresses for n = 40..63 read as 0 and ignore writes.
- R11: If a source's flag is set in the same cycle that software clears it, the flag stays set.
- R12: Reads of any address not listed here return 0. Writes to such addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe; a write takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| prim_in | input | 39 | Raw inputs of primary sources 1 to 39 (bit index = source number) |
| sec_in | input | 32 | Raw active-high inputs of the secondary group |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
There are two internal failure modes to watch for.

- **Corrupt enable or pending bits.** These show up on `cpu_irq` one cycle after the edge that stores the bad value, and the bench compares that line on every clock.
- **Wrong capture mode, polarity or cascade.** These show up as a wrong index at 0x40 or wrong pending bits on the read port in the cycle after the input event. For a cascaded source the error appears two cycles after the input event, because the secondary latch adds one register.

The reference model in the bench steps the same inputs through its own arrays, so a divergence is reported in the first cycle where it becomes visible.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_PEND   = 12'h010;
    localparam logic [ADDR_W-1:0] A_ENSET  = 12'h020;
    localparam logic [ADDR_W-1:0] A_ENCLR  = 12'h030;
    localparam logic [ADDR_W-1:0] A_PRIO   = 12'h040;
    localparam logic [ADDR_W-1:0] A_POL    = 12'h050;
    localparam logic [ADDR_W-1:0] A_TYPE   = 12'h060;
    localparam logic [ADDR_W-1:0] A_SSTAT  = 12'h080;
    localparam logic [ADDR_W-1:0] A_SCLR   = 12'h088;
    localparam logic [ADDR_W-1:0] A_SENSET = 12'h090;
    localparam logic [ADDR_W-1:0] A_SENCLR = 12'h098;
    localparam logic [ADDR_W-1:0] A_MAP    = 12'h200;

    typedef enum logic [3:0] {
        R_NONE, R_PEND, R_ENSET, R_ENCLR, R_PRIO, R_POL, R_TYPE,
        R_SSTAT, R_SCLR, R_SENSET, R_SENCLR, R_MAP
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic       hi;
        logic [5:0] map_idx;
    } decode_t;

    // Maps a byte address to a register kind, word half and map slot.
    function automatic decode_t reg_decode(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.sel     = R_NONE;
        d.hi      = 1'b0;
        d.map_idx = a[7:2];
        case (a)
            A_PEND:          d.sel = R_PEND;
            A_PEND + 12'h4:  begin d.sel = R_PEND;  d.hi = 1'b1; end
            A_ENSET:         d.sel = R_ENSET;
            A_ENSET + 12'h4: begin d.sel = R_ENSET; d.hi = 1'b1; end
            A_ENCLR:         d.sel = R_ENCLR;
            A_ENCLR + 12'h4: begin d.sel = R_ENCLR; d.hi = 1'b1; end
            A_PRIO:          d.sel = R_PRIO;
            A_POL:           d.sel = R_POL;
            A_POL + 12'h4:   begin d.sel = R_POL;   d.hi = 1'b1; end
            A_TYPE:          d.sel = R_TYPE;
            A_TYPE + 12'h4:  begin d.sel = R_TYPE;  d.hi = 1'b1; end
            A_SSTAT:         d.sel = R_SSTAT;
            A_SCLR:          d.sel = R_SCLR;
            A_SENSET:        d.sel = R_SENSET;
            A_SENCLR:        d.sel = R_SENCLR;
            default: begin
                if (a[ADDR_W-1:8] == A_MAP[ADDR_W-1:8] && a[1:0] == 2'b00)
                    d.sel = R_MAP;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/irqc_src_cell.sv
`timescale 1ns/1ps
module irqc_src_cell (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic active_low,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic act;
    logic act_prev;
    logic set_now;

    always_comb begin
        act     = raw ^ active_low;
        set_now = edge_mode ? (act & ~act_prev) : act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_prev <= 1'b0;
            pend     <= 1'b0;
        end else begin
            act_prev <= act;
            pend     <= set_now | (pend & ~clr);
        end
    end
endmodule

// File: rtl/irqc_prio_enc.sv
`timescale 1ns/1ps
module irqc_prio_enc #(
    parameter int N  = 40,
    parameter int IW = 6
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          valid
);
    always_comb begin
        idx = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        valid = |req;
    end
endmodule

// File: rtl/irqc_chan_map.sv
`timescale 1ns/1ps
module irqc_chan_map #(
    parameter int N  = 40,
    parameter int IW = 6,
    parameter int W  = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] slot_q [N];
    logic         in_range;

    assign in_range = (32'(idx) < N);
    assign rdata    = in_range ? slot_q[idx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) slot_q[i] <= W'(i);
        end else if (we && in_range) begin
            slot_q[idx] <= wdata;
        end
    end
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NPRI = 40,
    parameter int NSEC = 32,
    parameter int DW   = 32,
    parameter int IDXW = 6,
    parameter int MAPW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPRI-1:1]   prim_in,
    input  logic [NSEC-1:0]   sec_in,
    output logic              cpu_irq
);
    localparam int NHI = NPRI - DW;

    decode_t          dec;
    logic [NPRI-1:0]  wmask;
    logic [NPRI-1:0]  pclr_m, enset_m, enclr_m;
    logic [NPRI-1:0]  pend_q, en_q, pol_q, type_q;
    logic [NPRI-1:0]  src_raw, req_v;
    logic [NSEC-1:0]  sec_pend_q, sec_en_q;
    logic [NSEC-1:0]  sclr_m, senset_m, senclr_m;
    logic             cascade;
    logic [IDXW-1:0]  prio_idx;
    logic             prio_valid;
    logic             map_we;
    logic [MAPW-1:0]  map_rdata;

    function automatic logic [DW-1:0] pick(input logic [NPRI-1:0] v, input logic hi);
        return hi ? DW'(v[NPRI-1:DW]) : v[DW-1:0];
    endfunction

    always_comb begin
        dec      = reg_decode(bus_addr);
        wmask    = dec.hi ? {bus_wdata[NHI-1:0], {DW{1'b0}}} : {{NHI{1'b0}}, bus_wdata};
        pclr_m   = (bus_wr && dec.sel == R_PEND)   ? wmask : '0;
        enset_m  = (bus_wr && dec.sel == R_ENSET)  ? wmask : '0;
        enclr_m  = (bus_wr && dec.sel == R_ENCLR)  ? wmask : '0;
        sclr_m   = (bus_wr && dec.sel == R_SCLR)   ? bus_wdata[NSEC-1:0] : '0;
        senset_m = (bus_wr && dec.sel == R_SENSET) ? bus_wdata[NSEC-1:0] : '0;
        senclr_m = (bus_wr && dec.sel == R_SENCLR) ? bus_wdata[NSEC-1:0] : '0;
        map_we   = bus_wr && dec.sel == R_MAP;
    end

    // Primary enables and per-source configuration
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= '0;
            type_q <= '0;
        end else begin
            en_q <= (en_q | enset_m) & ~enclr_m;
            if (bus_wr && dec.sel == R_POL)
                pol_q <= dec.hi ? {bus_wdata[NHI-1:0], pol_q[DW-1:0]}
                                : {pol_q[NPRI-1:DW], bus_wdata};
            if (bus_wr && dec.sel == R_TYPE)
                type_q <= dec.hi ? {bus_wdata[NHI-1:0], type_q[DW-1:0]}
                                 : {type_q[NPRI-1:DW], bus_wdata};
        end
    end

    // Secondary group: level latch with write-one clear
    always_ff @(posedge clk) begin
        if (rst) begin
            sec_pend_q <= '0;
            sec_en_q   <= '0;
        end else begin
            sec_pend_q <= sec_in | (sec_pend_q & ~sclr_m);
            sec_en_q   <= (sec_en_q | senset_m) & ~senclr_m;
        end
    end

    assign cascade = |(sec_pend_q & sec_en_q);
    assign src_raw = {prim_in, cascade};

    for (genvar g = 0; g < NPRI; g++) begin : g_src
        irqc_src_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .raw        (src_raw[g]),
            .active_low (pol_q[g]),
            .edge_mode  (type_q[g]),
            .clr        (pclr_m[g]),
            .pend       (pend_q[g])
        );
    end

    assign req_v = pend_q & en_q;

    irqc_prio_enc #(.N(NPRI), .IW(IDXW)) u_prio (
        .req   (req_v),
        .idx   (prio_idx),
        .valid (prio_valid)
    );

    irqc_chan_map #(.N(NPRI), .IW(6), .W(MAPW)) u_map (
        .clk   (clk),
        .rst   (rst),
        .we    (map_we),
        .idx   (dec.map_idx),
        .wdata (bus_wdata[MAPW-1:0]),
        .rdata (map_rdata)
    );

    assign cpu_irq = prio_valid;

    always_comb begin
        case (dec.sel)
            R_PEND:             bus_rdata = pick(pend_q, dec.hi);
            R_ENSET, R_ENCLR:   bus_rdata = pick(en_q, dec.hi);
            R_PRIO:             bus_rdata = DW'(prio_idx);
            R_POL:              bus_rdata = pick(pol_q, dec.hi);
            R_TYPE:             bus_rdata = pick(type_q, dec.hi);
            R_SSTAT, R_SCLR:    bus_rdata = DW'(sec_pend_q);
            R_SENSET, R_SENCLR: bus_rdata = DW'(sec_en_q);
            R_MAP:              bus_rdata = DW'(map_rdata);
            default:            bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NPRI = 40,
    parameter int NSEC = 32,
    parameter int DW   = 32,
    parameter int IDXW = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DW-1:0]     bus_wdata,
    input logic              cpu_irq,
    input logic [IDXW-1:0]   prio_idx,
    input logic [NPRI-1:0]   pend_q,
    input logic [NPRI-1:0]   en_q,
    input logic [NPRI-1:0]   pol_q,
    input logic [NPRI-1:0]   type_q,
    input logic [NSEC-1:0]   sec_pend_q,
    input logic [NSEC-1:0]   sec_en_q
);
    localparam int NHI = NPRI - DW;

    logic [NPRI-1:0] clr_full;
    logic [NPRI-1:0] won_v;
    logic [NSEC-1:0] sclr_full;

    assign clr_full  = (bus_wr && bus_addr == A_PEND)          ? {{NHI{1'b0}}, bus_wdata} :
                       (bus_wr && bus_addr == A_PEND + 12'h4)  ? {bus_wdata[NHI-1:0], {DW{1'b0}}} : '0;
    assign sclr_full = (bus_wr && bus_addr == A_SCLR) ? bus_wdata[NSEC-1:0] : '0;
    assign won_v     = (pend_q & en_q) >> prio_idx;

    p_enset_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_ENSET) |=> ((en_q[DW-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

    p_enclr_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_ENCLR) |=> ((en_q[DW-1:0] & $past(bus_wdata)) == '0));

    p_pend_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (($past(pend_q) & ~pend_q & ~$past(clr_full)) == '0));

    p_prio_valid_r4: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> won_v[0]);

    p_irq_line_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_irq == (|(pend_q & en_q)));

    p_sec_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (($past(sec_pend_q) & ~sec_pend_q & ~$past(sclr_full)) == '0));

    p_cascade_r9: assert property (@(posedge clk) disable iff (rst)
        ((|(sec_pend_q & sec_en_q)) && !pol_q[0] && !type_q[0]) |=> pend_q[0]);

endmodule

bind irqc_top irqc_checker #(.NPRI(NPRI), .NSEC(NSEC), .DW(DW), .IDXW(IDXW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .cpu_irq    (cpu_irq),
    .prio_idx   (prio_idx),
    .pend_q     (pend_q),
    .en_q       (en_q),
    .pol_q      (pol_q),
    .type_q     (type_q),
    .sec_pend_q (sec_pend_q),
    .sec_en_q   (sec_en_q)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [39:1] prim_in = '0;
    logic [31:0] sec_in = '0;
    logic        cpu_irq;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prim_in(prim_in),
        .sec_in(sec_in), .cpu_irq(cpu_irq)
    );

    // Behavioural reference model
    bit m_pend[40], m_en[40], m_pol[40], m_typ[40], m_prev[40];
    bit m_spend[32], m_sen[32];
    int m_map[40];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 40; i++) begin
                m_pend[i] = 0; m_en[i] = 0; m_pol[i] = 0; m_typ[i] = 0; m_prev[i] = 0;
                m_map[i] = i;
            end
            for (int j = 0; j < 32; j++) begin m_spend[j] = 0; m_sen[j] = 0; end
        end else begin
            bit casc;
            casc = 0;
            for (int j = 0; j < 32; j++) if (m_spend[j] && m_sen[j]) casc = 1;
            for (int i = 0; i < 40; i++) begin
                bit raw, act, setv, clr;
                if (i == 0) raw = casc; else raw = prim_in[i];
                act  = raw ^ m_pol[i];
                setv = m_typ[i] ? (act && !m_prev[i]) : act;
                clr  = bus_wr && ((bus_addr == 12'h010 && i < 32 && bus_wdata[i % 32]) ||
                                  (bus_addr == 12'h014 && i >= 32 && bus_wdata[i % 32]));
                m_pend[i] = setv || (m_pend[i] && !clr);
                m_prev[i] = act;
            end
            for (int j = 0; j < 32; j++)
                m_spend[j] = sec_in[j] || (m_spend[j] && !(bus_wr && bus_addr == 12'h088 && bus_wdata[j]));
            if (bus_wr) begin
                for (int i = 0; i < 40; i++) begin
                    bit lo, b;
                    lo = (i < 32);
                    b  = bus_wdata[i % 32];
                    if (bus_addr == (lo ? 12'h020 : 12'h024) && b) m_en[i] = 1;
                    if (bus_addr == (lo ? 12'h030 : 12'h034) && b) m_en[i] = 0;
                    if (bus_addr == (lo ? 12'h050 : 12'h054)) m_pol[i] = b;
                    if (bus_addr == (lo ? 12'h060 : 12'h064)) m_typ[i] = b;
                end
                for (int j = 0; j < 32; j++) begin
                    if (bus_addr == 12'h090 && bus_wdata[j]) m_sen[j] = 1;
                    if (bus_addr == 12'h098 && bus_wdata[j]) m_sen[j] = 0;
                end
                if (bus_addr >= 12'h200 && bus_addr < 12'h200 + 12'd160 && bus_addr[1:0] == 2'b00)
                    m_map[(bus_addr - 12'h200) / 4] = bus_wdata[5:0];
            end
        end
    end

    function automatic int m_prio();
        for (int i = 0; i < 40; i++) if (m_pend[i] && m_en[i]) return i;
        return 63;
    endfunction

    function automatic logic [31:0] vec_word(input bit v[40], input bit hi);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < 40; i++) begin
            if (!hi && i < 32) w[i] = v[i];
            if (hi && i >= 32) w[i - 32] = v[i];
        end
        return w;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        logic [31:0] w;
        w = '0;
        case (a)
            12'h010: w = vec_word(m_pend, 0);
            12'h014: w = vec_word(m_pend, 1);
            12'h020, 12'h030: w = vec_word(m_en, 0);
            12'h024, 12'h034: w = vec_word(m_en, 1);
            12'h040: w = 32'(m_prio());
            12'h050: w = vec_word(m_pol, 0);
            12'h054: w = vec_word(m_pol, 1);
            12'h060: w = vec_word(m_typ, 0);
            12'h064: w = vec_word(m_typ, 1);
            12'h080, 12'h088: for (int j = 0; j < 32; j++) w[j] = m_spend[j];
            12'h090, 12'h098: for (int j = 0; j < 32; j++) w[j] = m_sen[j];
            default: if (a >= 12'h200 && a < 12'h200 + 12'd160 && a[1:0] == 2'b00)
                         w = 32'(m_map[(a - 12'h200) / 4]);
        endcase
        return w;
    endfunction

    // Every-cycle comparison of the request line (R5)
    always @(posedge clk) begin
        #5;
        if (!rst && !done) begin
            nchk++;
            if (cpu_irq !== (m_prio() != 63)) begin
                nfail++;
                $display("FAIL R5 cpu_irq actual=%0b expected=%0b at %0t", cpu_irq, (m_prio() != 63), $time);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #2;
        exp = m_read(a);
        nchk++;
        if (bus_rdata !== exp) begin
            nfail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_chk(12'h010, "R1"); rd_chk(12'h014, "R1"); rd_chk(12'h020, "R1");
        rd_chk(12'h040, "R1"); rd_chk(12'h050, "R1"); rd_chk(12'h060, "R1");
        rd_chk(12'h080, "R1"); rd_chk(12'h090, "R1");
        nchk++;
        if (cpu_irq !== 1'b0) begin nfail++; $display("FAIL R1 cpu_irq actual=%0b expected=0", cpu_irq); end
        rd_chk(12'h214, "R10");

        // R3 pending latches while disabled, W1C clears
        @(negedge clk); prim_in[5] = 1'b1;
        @(negedge clk); prim_in[5] = 1'b0;
        rd_chk(12'h010, "R3"); rd_chk(12'h040, "R4");
        wr(12'h010, 32'h0000_0020);
        rd_chk(12'h010, "R3");

        // R2 enable set / clear on both words
        wr(12'h020, 32'h0000_0120);
        rd_chk(12'h020, "R2"); rd_chk(12'h030, "R2");
        wr(12'h024, 32'h0000_0081);
        rd_chk(12'h024, "R2"); rd_chk(12'h034, "R2");
        wr(12'h030, 32'h0000_0100);
        rd_chk(12'h020, "R2");
        wr(12'h020, 32'h0);
        rd_chk(12'h020, "R2");
        wr(12'h020, 32'h0000_0100);

        // R4 lowest wins, R5 line
        @(negedge clk); prim_in[8] = 1'b1; prim_in[39] = 1'b1;
        @(negedge clk); prim_in[8] = 1'b0; prim_in[39] = 1'b0;
        rd_chk(12'h040, "R4"); rd_chk(12'h014, "R3");
        wr(12'h010, 32'h0000_0100);
        rd_chk(12'h040, "R4");
        wr(12'h014, 32'h0000_0080);
        rd_chk(12'h040, "R4");

        // R7 level: clear ineffective while held
        @(negedge clk); prim_in[5] = 1'b1;
        idle(2);
        wr(12'h010, 32'h0000_0020);
        rd_chk(12'h010, "R7"); rd_chk(12'h040, "R7");
        @(negedge clk); prim_in[5] = 1'b0;
        wr(12'h010, 32'h0000_0020);
        rd_chk(12'h010, "R7");

        // R7 edge: one capture per rising edge
        wr(12'h060, 32'h0000_0020);
        @(negedge clk); prim_in[5] = 1'b1;
        idle(2);
        rd_chk(12'h010, "R7");
        wr(12'h010, 32'h0000_0020);
        idle(2);
        rd_chk(12'h010, "R7");
        @(negedge clk); prim_in[5] = 1'b0;
        @(negedge clk); prim_in[5] = 1'b1;
        @(negedge clk); prim_in[5] = 1'b0;
        rd_chk(12'h010, "R7");
        wr(12'h010, 32'h0000_0020);
        wr(12'h060, 32'h0);

        // R6 active-low source 8
        wr(12'h050, 32'h0000_0100);
        rd_chk(12'h050, "R6"); rd_chk(12'h040, "R6");
        @(negedge clk); prim_in[8] = 1'b1;
        wr(12'h010, 32'h0000_0100);
        rd_chk(12'h010, "R6"); rd_chk(12'h040, "R6");
        wr(12'h050, 32'h0);
        @(negedge clk); prim_in[8] = 1'b0;
        wr(12'h010, 32'h0000_0100);
        rd_chk(12'h010, "R6");

        // R8 / R9 secondary group and cascade
        @(negedge clk); sec_in[3] = 1'b1;
        @(negedge clk); sec_in[3] = 1'b0;
        rd_chk(12'h080, "R8"); rd_chk(12'h088, "R8"); rd_chk(12'h010, "R9");
        wr(12'h020, 32'h0000_0001);
        wr(12'h090, 32'h0000_0008);
        rd_chk(12'h090, "R8"); rd_chk(12'h098, "R8");
        idle(1);
        rd_chk(12'h040, "R9");
        wr(12'h088, 32'h0000_0008);
        rd_chk(12'h080, "R8");
        wr(12'h010, 32'h0000_0001);
        rd_chk(12'h010, "R9"); rd_chk(12'h040, "R9");
        wr(12'h098, 32'h0000_0008);
        rd_chk(12'h098, "R8");

        // R11 set beats clear in the same cycle
        @(negedge clk);
        prim_in[9] = 1'b1; bus_addr = 12'h010; bus_wdata = 32'h0000_0200; bus_wr = 1'b1;
        @(posedge clk); #1; bus_wr = 1'b0; prim_in[9] = 1'b0;
        rd_chk(12'h010, "R11");
        wr(12'h010, 32'h0000_0200);
        rd_chk(12'h010, "R11");

        // R10 channel map, R12 unmapped
        wr(12'h21C, 32'h0000_002A);
        rd_chk(12'h21C, "R10"); rd_chk(12'h29C, "R10");
        wr(12'h2B4, 32'h0000_0015);
        rd_chk(12'h2B4, "R10");
        wr(12'h070, 32'hFFFF_FFFF);
        rd_chk(12'h070, "R12"); rd_chk(12'h020, "R12"); rd_chk(12'h050, "R12");

        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule